// File: doc/BRIEF.md
# Three-Port Latched Bus Exchanger

This block moves 12-bit words between a single A-side bus and two B-side buses, called B1 and B2. It holds four independent level-sensitive storage paths: A to B1, A to B2, B1 to A and B2 to A. Each path has its own enable. While an enable is high, its path passes data straight through. When the enable falls, the path keeps the word present at that instant. It keeps that word until the enable rises again.

A select input chooses which of the two B-to-A paths reaches the A bus. Each port has an active-low output enable. Because of this, one B bus can be driven from A while the other B bus feeds a word back toward A. One A bus can therefore serve two interleaved memory banks, or take addresses from two sources in turn.

Bidirectional pins are split into an input, an output and an output-valid flag per port. There is no clock. An active-low asynchronous reset clears all four storage paths.

Top module: `bxExchanger`

## Requirements
- R1: While `rstN` is low, all four storage paths read as zero, so `aOut`, `b1Out` and `b2Out` are 0 whatever the inputs are.
- R2: With `rstN` high and `leAto1` high, `b1Out` follows `aIn` whenever the B1 driver is enabled (`oeB1N` = 0).
- R3: With `rstN` high and `leAto2` high, `b2Out` follows `aIn` whenever the B2 driver is enabled (`oeB2N` = 0).
- R4: When any of the four enables goes low, its path keeps the input word present at that moment. Changes on that input have no effect on the path's output until the enable returns high.
- R5: With `le1toA` high, the B1-to-A path follows `b1In`. With `le2toA` high, the B2-to-A path follows `b2In`.
- R6: `aOut` shows the B1-to-A path when `selB1` = 1 and the B2-to-A path when `selB1` = 0, provided `oeAN` = 0.
- R7: The output enables `oeAN`, `oeB1N` and `oeB2N` are active low. A disabled port has its flag (`aOe`, `b1Oe`, `b2Oe`) at 0 and its data output at 0, and the stored word is unaffected.
- R8: With both `leAto1` and `leAto2` high, one A word is written to B1 and B2 at the same time. After both enables fall, both ports keep that word.
- R9: The B output enables are independent. B1 can drive a stored A word out while B2 is disabled and its input is passed through the B2-to-A path to the A bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low clear of all storage |
| aIn | input | 12 | Word arriving on the A bus |
| aOut | output | 12 | Word driven onto the A bus (0 when disabled) |
| aOe | output | 1 | A driver active |
| b1In | input | 12 | Word arriving on the B1 bus |
| b1Out | output | 12 | Word driven onto the B1 bus (0 when disabled) |
| b1Oe | output | 1 | B1 driver active |
| b2In | input | 12 | Word arriving on the B2 bus |
| b2Out | output | 12 | Word driven onto the B2 bus (0 when disabled) |
| b2Oe | output | 1 | B2 driver active |
| leAto1 | input | 1 | Transparent-high enable, A to B1 path |
| leAto2 | input | 1 | Transparent-high enable, A to B2 path |
| le1toA | input | 1 | Transparent-high enable, B1 to A path |
| le2toA | input | 1 | Transparent-high enable, B2 to A path |
| selB1 | input | 1 | 1 selects the B1-to-A path for A, 0 selects B2-to-A |
| oeAN | input | 1 | Active-low A driver enable |
| oeB1N | input | 1 | Active-low B1 driver enable |
| oeB2N | input | 1 | Active-low B2 driver enable |

## Verification
The bench builds the block with its default 12-bit width. At that width, alternating and all-ones patterns show any bit that is dropped or swapped between paths. A behavioural model keeps one integer per storage path and compares all six outputs every clock. Directed phases cover reset, transparency and holding on each path, the dual write, select toggling, disabled drivers, and one B port driving while the other feeds A. A pseudo-random phase then toggles enables and data on the same step, which exercises the moment each path captures its word.

// File: rtl/bxPkg.sv
package bxPkg;
  // Strobes passed from control to datapath, all active high.
  typedef struct packed {
    logic capAto1;   // A to B1 path transparent
    logic capAto2;   // A to B2 path transparent
    logic cap1toA;   // B1 to A path transparent
    logic cap2toA;   // B2 to A path transparent
    logic pickB1;    // A bus fed from B1 path
    logic driveA;
    logic driveB1;
    logic driveB2;
  } bxStrobes_t;

  localparam int unsigned NUM_B = 2;
endpackage

// File: rtl/bxLatchCell.sv
module bxLatchCell #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             rstN,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // Level-sensitive storage: passes d while en is high, holds otherwise.
  always_latch begin
    if (!rstN)   q = '0;
    else if (en) q = d;
  end
endmodule

// File: rtl/bxControl.sv
module bxControl (
  input  logic              leAto1,
  input  logic              leAto2,
  input  logic              le1toA,
  input  logic              le2toA,
  input  logic              selB1,
  input  logic              oeAN,
  input  logic              oeB1N,
  input  logic              oeB2N,
  output bxPkg::bxStrobes_t strobes
);
  // Converts the pin-level polarities into active-high strobes.
  always_comb begin
    strobes.capAto1 = leAto1;
    strobes.capAto2 = leAto2;
    strobes.cap1toA = le1toA;
    strobes.cap2toA = le2toA;
    strobes.pickB1  = selB1;
    strobes.driveA  = ~oeAN;
    strobes.driveB1 = ~oeB1N;
    strobes.driveB2 = ~oeB2N;
  end
endmodule

// File: rtl/bxDatapath.sv
module bxDatapath #(
  parameter int unsigned WIDTH = 12
) (
  input  logic              rstN,
  input  bxPkg::bxStrobes_t strobes,
  input  logic [WIDTH-1:0]  aIn,
  input  logic [WIDTH-1:0]  b1In,
  input  logic [WIDTH-1:0]  b2In,
  output logic [WIDTH-1:0]  aOut,
  output logic              aOe,
  output logic [WIDTH-1:0]  b1Out,
  output logic              b1Oe,
  output logic [WIDTH-1:0]  b2Out,
  output logic              b2Oe
);
  localparam int unsigned NB = bxPkg::NUM_B;

  logic [WIDTH-1:0] bInArr   [NB];
  logic [WIDTH-1:0] toBQ     [NB];
  logic [WIDTH-1:0] fromBQ   [NB];
  logic             toBEn    [NB];
  logic             fromBEn  [NB];
  logic             bDrive   [NB];
  logic [WIDTH-1:0] bOutArr  [NB];
  logic [WIDTH-1:0] aSel;

  always_comb begin
    bInArr[0]  = b1In;
    bInArr[1]  = b2In;
    toBEn[0]   = strobes.capAto1;
    toBEn[1]   = strobes.capAto2;
    fromBEn[0] = strobes.cap1toA;
    fromBEn[1] = strobes.cap2toA;
    bDrive[0]  = strobes.driveB1;
    bDrive[1]  = strobes.driveB2;
  end

  for (genvar gi = 0; gi < NB; gi++) begin : gPort
    bxLatchCell #(.WIDTH(WIDTH)) uToB (
      .rstN (rstN),
      .en   (toBEn[gi]),
      .d    (aIn),
      .q    (toBQ[gi])
    );
    bxLatchCell #(.WIDTH(WIDTH)) uFromB (
      .rstN (rstN),
      .en   (fromBEn[gi]),
      .d    (bInArr[gi]),
      .q    (fromBQ[gi])
    );
    assign bOutArr[gi] = bDrive[gi] ? toBQ[gi] : '0;
  end

  assign aSel  = strobes.pickB1 ? fromBQ[0] : fromBQ[1];
  assign aOut  = strobes.driveA ? aSel : '0;
  assign aOe   = strobes.driveA;
  assign b1Out = bOutArr[0];
  assign b2Out = bOutArr[1];
  assign b1Oe  = bDrive[0];
  assign b2Oe  = bDrive[1];
endmodule

// File: rtl/bxExchanger.sv
module bxExchanger #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             rstN,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] b1In,
  output logic [WIDTH-1:0] b1Out,
  output logic             b1Oe,
  input  logic [WIDTH-1:0] b2In,
  output logic [WIDTH-1:0] b2Out,
  output logic             b2Oe,
  input  logic             leAto1,
  input  logic             leAto2,
  input  logic             le1toA,
  input  logic             le2toA,
  input  logic             selB1,
  input  logic             oeAN,
  input  logic             oeB1N,
  input  logic             oeB2N
);
  bxPkg::bxStrobes_t strobes;

  bxControl uCtrl (
    .leAto1  (leAto1),
    .leAto2  (leAto2),
    .le1toA  (le1toA),
    .le2toA  (le2toA),
    .selB1   (selB1),
    .oeAN    (oeAN),
    .oeB1N   (oeB1N),
    .oeB2N   (oeB2N),
    .strobes (strobes)
  );

  bxDatapath #(.WIDTH(WIDTH)) uData (
    .rstN    (rstN),
    .strobes (strobes),
    .aIn     (aIn),
    .b1In    (b1In),
    .b2In    (b2In),
    .aOut    (aOut),
    .aOe     (aOe),
    .b1Out   (b1Out),
    .b1Oe    (b1Oe),
    .b2Out   (b2Out),
    .b2Oe    (b2Oe)
  );
endmodule

// File: rtl/bxExchangerChk.sv
module bxExchangerChk #(
  parameter int unsigned WIDTH = 12
) (
  input logic             rstN,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] aOut,
  input logic             aOe,
  input logic [WIDTH-1:0] b1In,
  input logic [WIDTH-1:0] b1Out,
  input logic             b1Oe,
  input logic [WIDTH-1:0] b2In,
  input logic [WIDTH-1:0] b2Out,
  input logic             b2Oe,
  input logic             leAto1,
  input logic             leAto2,
  input logic             le1toA,
  input logic             le2toA,
  input logic             selB1,
  input logic             oeAN,
  input logic             oeB1N,
  input logic             oeB2N
);
  // No clock exists in this block, so the checks are immediate ones on settled values.
  always_comb begin
    AST_RESET_CLEAR: assert (rstN || (aOut == '0 && b1Out == '0 && b2Out == '0)); // R1
    AST_A_TO_B1_FLOW: assert (!(rstN && leAto1 && !oeB1N) || b1Out == aIn); // R2
    AST_A_TO_B2_FLOW: assert (!(rstN && leAto2 && !oeB2N) || b2Out == aIn); // R3
    AST_B1_TO_A_FLOW: assert (!(rstN && le1toA && selB1 && !oeAN) || aOut == b1In); // R5
    AST_PICK_B2_PATH: assert (!(rstN && le1toA && le2toA && !selB1 && !oeAN) || aOut == b2In); // R6
    AST_A_QUIET: assert (!oeAN || (aOut == '0 && !aOe)); // R7
    AST_B1_QUIET: assert (!oeB1N || (b1Out == '0 && !b1Oe)); // R7
    AST_B2_QUIET: assert (!oeB2N || (b2Out == '0 && !b2Oe)); // R7
  end
endmodule

bind bxExchanger bxExchangerChk #(.WIDTH(WIDTH)) u_chk (
  .rstN   (rstN),
  .aIn    (aIn),
  .aOut   (aOut),
  .aOe    (aOe),
  .b1In   (b1In),
  .b1Out  (b1Out),
  .b1Oe   (b1Oe),
  .b2In   (b2In),
  .b2Out  (b2Out),
  .b2Oe   (b2Oe),
  .leAto1 (leAto1),
  .leAto2 (leAto2),
  .le1toA (le1toA),
  .le2toA (le2toA),
  .selB1  (selB1),
  .oeAN   (oeAN),
  .oeB1N  (oeB1N),
  .oeB2N  (oeB2N)
);

// File: tb/bxExchanger_tb.sv
module bxExchanger_tb;
  localparam int W = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic         rstN;
  logic [W-1:0] aIn, b1In, b2In;
  logic [W-1:0] aOut, b1Out, b2Out;
  logic         aOe, b1Oe, b2Oe;
  logic         leAto1, leAto2, le1toA, le2toA, selB1;
  logic         oeAN, oeB1N, oeB2N;

  bxExchanger #(.WIDTH(W)) u_dut (
    .rstN(rstN), .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .b1In(b1In), .b1Out(b1Out), .b1Oe(b1Oe),
    .b2In(b2In), .b2Out(b2Out), .b2Oe(b2Oe),
    .leAto1(leAto1), .leAto2(leAto2), .le1toA(le1toA), .le2toA(le2toA),
    .selB1(selB1), .oeAN(oeAN), .oeB1N(oeB1N), .oeB2N(oeB2N)
  );

  // Behavioural model: one integer per storage path.
  int mAto1, mAto2, m1toA, m2toA;
  int nChecks = 0;
  int nFails  = 0;
  string curReq = "R1";

  task automatic checkOne(string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, what, act, exp);
    end
  endtask

  // Model update after inputs settle, then compare at the falling edge.
  task automatic tick();
    int expA, expB1, expB2;
    if (!rstN) begin
      mAto1 = 0; mAto2 = 0; m1toA = 0; m2toA = 0;
    end else begin
      if (leAto1) mAto1 = int'(aIn);
      if (leAto2) mAto2 = int'(aIn);
      if (le1toA) m1toA = int'(b1In);
      if (le2toA) m2toA = int'(b2In);
    end
    expA  = oeAN  ? 0 : (selB1 ? m1toA : m2toA);
    expB1 = oeB1N ? 0 : mAto1;
    expB2 = oeB2N ? 0 : mAto2;
    @(negedge clk);
    checkOne("aOut",  int'(aOut),  expA);
    checkOne("aOe",   int'(aOe),   oeAN ? 0 : 1);
    checkOne("b1Out", int'(b1Out), expB1);
    checkOne("b1Oe",  int'(b1Oe),  oeB1N ? 0 : 1);
    checkOne("b2Out", int'(b2Out), expB2);
    checkOne("b2Oe",  int'(b2Oe),  oeB2N ? 0 : 1);
    @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; aIn = 12'hFFF; b1In = 12'hAAA; b2In = 12'h555;
    leAto1 = 1; leAto2 = 1; le1toA = 1; le2toA = 1; selB1 = 1;
    oeAN = 0; oeB1N = 0; oeB2N = 0;
    mAto1 = 0; mAto2 = 0; m1toA = 0; m2toA = 0;
    @(posedge clk);

    // R1: reset clears every path even with transparent enables
    curReq = "R1";
    tick(); selB1 = 0; tick();
    leAto1 = 0; leAto2 = 0; le1toA = 0; le2toA = 0;
    tick();
    rstN = 1; tick();

    // R2: A to B1 transparent, then hold (R4)
    curReq = "R2";
    aIn = 12'hA5A; leAto1 = 1; tick();
    aIn = 12'h3C3; tick();
    curReq = "R4";
    leAto1 = 0; tick();
    aIn = 12'h0F0; tick();
    aIn = 12'hFFF; tick();

    // R3: A to B2 transparent, then hold
    curReq = "R3";
    aIn = 12'h5A5; leAto2 = 1; tick();
    aIn = 12'h123; tick();
    curReq = "R4";
    leAto2 = 0; tick();
    aIn = 12'hEDC; tick();

    // R8: one A word into both B ports
    curReq = "R8";
    aIn = 12'h7E1; leAto1 = 1; leAto2 = 1; tick();
    leAto1 = 0; leAto2 = 0; tick();
    aIn = 12'h000; tick();

    // R5 / R6: B-to-A paths and the select
    curReq = "R5";
    b1In = 12'hABC; b2In = 12'hDEF; le1toA = 1; le2toA = 1; selB1 = 1; tick();
    b1In = 12'h111; tick();
    curReq = "R6";
    selB1 = 0; tick();
    b2In = 12'h222; tick();
    selB1 = 1; tick();
    curReq = "R4";
    le1toA = 0; tick();
    b1In = 12'h999; tick();
    le2toA = 0; b2In = 12'h888; selB1 = 0; tick();
    b2In = 12'h777; tick();

    // R7: disabled drivers are quiet and do not disturb storage
    curReq = "R7";
    oeAN = 1; oeB1N = 1; oeB2N = 1; aIn = 12'hFFF; tick();
    oeAN = 0; tick();
    oeB1N = 0; tick();
    oeB2N = 0; tick();

    // R9: B1 drives out while B2 feeds A
    curReq = "R9";
    aIn = 12'h4B4; leAto1 = 1; tick();
    leAto1 = 0; oeB1N = 0; oeB2N = 1; tick();
    b2In = 12'h6D6; le2toA = 1; selB1 = 0; tick();
    b2In = 12'h2D2; tick();
    le2toA = 0; b2In = 12'h000; tick();

    // R4: pseudo-random toggling of enables and data together
    curReq = "R4";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      aIn = W'($urandom); b1In = W'($urandom); b2In = W'($urandom);
      leAto1 = r[0]; leAto2 = r[1]; le1toA = r[2]; le2toA = r[3];
      selB1 = r[4]; oeAN = r[5] & r[6]; oeB1N = r[7] & r[8]; oeB2N = r[9] & r[10];
      tick();
    end

    // R1: reset again clears held words
    curReq = "R1";
    leAto1 = 0; leAto2 = 0; le1toA = 0; le2toA = 0;
    oeAN = 0; oeB1N = 0; oeB2N = 0;
    rstN = 0; tick();
    rstN = 1; tick();

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule